// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the control and status register file for a multi-channel DMA layer. A transmit channel set and a receive channel set each have up to 32 channels, and parameters set the channel counts. A register bus carries a word address and 32-bit data. Writes take effect on the clock edge at which `wr_en` is high. Read data comes back registered, one cycle after the address is presented.

The register file holds these registers:

- a global configuration word, whose top bit starts a self-clearing soft reset;
- an error status word and an interrupt enable;
- separate activate-set and activate-reset words for each direction;
- end-of-buffer and descriptor-error status words for each direction;
- per-channel descriptor table pointers, and per-channel receive buffer sizes.

Channel event pulses from the data-movement logic set status bits. Software clears them by writing ones.

Top module: `dmacr_regfile`

## Requirements
- R1: Word addresses (hex) decode as follows:
  - 180 is configuration, 181 is error status and 182 is interrupt enable.
  - 184 and 185 are transmit activate set and reset; 190 and 191 are the receive pair.
  - 186 and 187 are transmit end-of-buffer status and transmit descriptor-error status; 192 and 193 are the receive pair.
- R2: Synchronous reset sets configuration to 0x0007C000 and clears every other register, including the per-channel arrays and `rdata`.
- R3: A configuration write with bit 31 set clears error status, interrupt enable, all four activate words and all four end-of-buffer and descriptor-error words. In the same cycle, configuration stores the written value ANDed with 0x00FFC087, so bit 31 never reads back as one.
- R4: Write masks apply: interrupt enable keeps bits 4:0, transmit activate words keep bits 31:28, receive activate words keep bits 31:30, and buffer sizes keep bits 7:0.
- R5: Error status and the four end-of-buffer and descriptor-error words are write-1-to-clear. Zero bits in the written data leave the stored bits unchanged.
- R6: Channel i's end-of-buffer or descriptor-error pulse sets bit 31-i of the matching word, and `err_evt` bit k sets error status bit k. A set in the same cycle as a write-1-to-clear or a soft reset of that bit wins.
- R7: Transmit table pointers occupy 0x1A0+i for i below NTX, receive table pointers 0x1C0+i and receive buffer sizes 0x1E0+i for i below NRX. Addresses past the channel count are undecoded.
- R8: Undecoded addresses read as zero, and writes to them change no register.
- R9: `rdata` is registered: it shows the register selected by `addr` at the previous clock edge.
- R10: Table pointers and buffer sizes keep their values through a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| tx_eob_evt | input | NTX | Transmit end-of-buffer pulses, one per channel |
| tx_derr_evt | input | NTX | Transmit descriptor-error pulses |
| rx_eob_evt | input | NRX | Receive end-of-buffer pulses |
| rx_derr_evt | input | NRX | Receive descriptor-error pulses |
| err_evt | input | 32 | Error status set bits |
| rdata | output | 32 | Registered read data |

## Verification
The write-1-to-clear property holds only when no event for that word arrives in the same cycle, because set wins over clear. The property therefore carries that condition in its antecedent, and the bench drives events and clears together in a single dedicated collision scenario. The checks on soft reset and the interrupt-enable mask assume that `wdata` is stable while `wr_en` is high. The bench changes bus inputs only on falling edges, which keeps that assumption true.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
  typedef logic [31:0] word_t;

  localparam int unsigned A_CFG   = 32'h180;
  localparam int unsigned A_ERR   = 32'h181;
  localparam int unsigned A_IEN   = 32'h182;
  localparam int unsigned A_TXSET = 32'h184;
  localparam int unsigned A_TXCLR = 32'h185;
  localparam int unsigned A_TXEOB = 32'h186;
  localparam int unsigned A_TXDER = 32'h187;
  localparam int unsigned A_RXSET = 32'h190;
  localparam int unsigned A_RXCLR = 32'h191;
  localparam int unsigned A_RXEOB = 32'h192;
  localparam int unsigned A_RXDER = 32'h193;
  localparam int unsigned A_TXPTR = 32'h1A0;
  localparam int unsigned A_RXPTR = 32'h1C0;
  localparam int unsigned A_RXBSZ = 32'h1E0;

  localparam word_t M_CFG   = 32'h00FF_C087;
  localparam word_t M_IEN   = 32'h0000_001F;
  localparam word_t M_TXACT = 32'hF000_0000;
  localparam word_t M_RXACT = 32'hC000_0000;
  localparam word_t M_BSZ   = 32'h0000_00FF;
  localparam word_t CFG_RST = 32'h0007_C000;

  localparam int unsigned NUM_ST = 5;  // err, txeob, txder, rxeob, rxder
endpackage

// File: rtl/dmacr_evt_reg.sv
module dmacr_evt_reg
  import dmacr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  srst,
  input  logic  clr_we,
  input  word_t clr_mask,
  input  word_t set_vec,
  output word_t q
);
  word_t kept;

  always_comb begin
    if (srst)        kept = '0;
    else if (clr_we) kept = q & ~clr_mask;
    else             kept = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= kept | set_vec;
  end
endmodule

// File: rtl/dmacr_chan_ram.sv
module dmacr_chan_ram
  import dmacr_pkg::*;
#(
  parameter int unsigned N    = 32,
  parameter word_t       MASK = 32'hFFFF_FFFF,
  localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  word_t         wdata,
  input  logic [IW-1:0] ridx,
  output word_t         rd
);
  word_t mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata & MASK;
    end
  end

  assign rd = (32'(ridx) < N) ? mem[ridx] : '0;
endmodule

// File: rtl/dmacr_regfile.sv
module dmacr_regfile
  import dmacr_pkg::*;
#(
  parameter int unsigned NTX    = 32,
  parameter int unsigned NRX    = 32,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [NTX-1:0]    tx_eob_evt,
  input  logic [NTX-1:0]    tx_derr_evt,
  input  logic [NRX-1:0]    rx_eob_evt,
  input  logic [NRX-1:0]    rx_derr_evt,
  input  logic [31:0]       err_evt,
  output logic [31:0]       rdata
);
  localparam int unsigned TXI_W = (NTX > 1) ? $clog2(NTX) : 1;
  localparam int unsigned RXI_W = (NRX > 1) ? $clog2(NRX) : 1;
  localparam int unsigned ST_ADDR [NUM_ST] = '{A_ERR, A_TXEOB, A_TXDER, A_RXEOB, A_RXDER};

  logic [31:0] a32;
  assign a32 = 32'(addr);

  word_t cfg_q, ien_q, txset_q, txclr_q, rxset_q, rxclr_q;
  word_t st_q   [NUM_ST];
  word_t st_set [NUM_ST];

  logic srst;
  assign srst = wr_en && (a32 == A_CFG) && wdata[31];

  always_comb begin
    for (int k = 0; k < NUM_ST; k++) st_set[k] = '0;
    st_set[0] = err_evt;
    for (int i = 0; i < NTX; i++) begin
      st_set[1][31-i] = tx_eob_evt[i];
      st_set[2][31-i] = tx_derr_evt[i];
    end
    for (int i = 0; i < NRX; i++) begin
      st_set[3][31-i] = rx_eob_evt[i];
      st_set[4][31-i] = rx_derr_evt[i];
    end
  end

  for (genvar k = 0; k < NUM_ST; k++) begin : g_st
    dmacr_evt_reg u_st (
      .clk      (clk),
      .rst      (rst),
      .srst     (srst),
      .clr_we   (wr_en && (a32 == ST_ADDR[k])),
      .clr_mask (wdata),
      .set_vec  (st_set[k]),
      .q        (st_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= CFG_RST;
      ien_q   <= '0;
      txset_q <= '0;
      txclr_q <= '0;
      rxset_q <= '0;
      rxclr_q <= '0;
    end else if (wr_en) begin
      if (srst) begin
        ien_q   <= '0;
        txset_q <= '0;
        txclr_q <= '0;
        rxset_q <= '0;
        rxclr_q <= '0;
      end
      case (a32)
        A_CFG:   cfg_q   <= wdata & M_CFG;
        A_IEN:   ien_q   <= wdata & M_IEN;
        A_TXSET: txset_q <= wdata & M_TXACT;
        A_TXCLR: txclr_q <= wdata & M_TXACT;
        A_RXSET: rxset_q <= wdata & M_RXACT;
        A_RXCLR: rxclr_q <= wdata & M_RXACT;
        default: ;
      endcase
    end
  end

  logic in_txp, in_rxp, in_bsz;
  assign in_txp = (a32 >= A_TXPTR) && (a32 < A_TXPTR + NTX);
  assign in_rxp = (a32 >= A_RXPTR) && (a32 < A_RXPTR + NRX);
  assign in_bsz = (a32 >= A_RXBSZ) && (a32 < A_RXBSZ + NRX);

  logic [TXI_W-1:0] txi;
  logic [RXI_W-1:0] rxpi, bszi;
  assign txi  = TXI_W'(a32 - A_TXPTR);
  assign rxpi = RXI_W'(a32 - A_RXPTR);
  assign bszi = RXI_W'(a32 - A_RXBSZ);

  word_t txp_rd, rxp_rd, bsz_rd;

  dmacr_chan_ram #(.N(NTX)) u_txptr (
    .clk(clk), .rst(rst), .we(wr_en && in_txp), .widx(txi),
    .wdata(wdata), .ridx(txi), .rd(txp_rd)
  );
  dmacr_chan_ram #(.N(NRX)) u_rxptr (
    .clk(clk), .rst(rst), .we(wr_en && in_rxp), .widx(rxpi),
    .wdata(wdata), .ridx(rxpi), .rd(rxp_rd)
  );
  dmacr_chan_ram #(.N(NRX), .MASK(M_BSZ)) u_rxbsz (
    .clk(clk), .rst(rst), .we(wr_en && in_bsz), .widx(bszi),
    .wdata(wdata), .ridx(bszi), .rd(bsz_rd)
  );

  word_t rd_next;
  always_comb begin
    case (a32)
      A_CFG:   rd_next = cfg_q;
      A_ERR:   rd_next = st_q[0];
      A_IEN:   rd_next = ien_q;
      A_TXSET: rd_next = txset_q;
      A_TXCLR: rd_next = txclr_q;
      A_TXEOB: rd_next = st_q[1];
      A_TXDER: rd_next = st_q[2];
      A_RXSET: rd_next = rxset_q;
      A_RXCLR: rd_next = rxclr_q;
      A_RXEOB: rd_next = st_q[3];
      A_RXDER: rd_next = st_q[4];
      default: rd_next = '0;
    endcase
    if (in_txp) rd_next = txp_rd;
    if (in_rxp) rd_next = rxp_rd;
    if (in_bsz) rd_next = bsz_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/dmacr_regfile_chk.sv
module dmacr_regfile_chk
  import dmacr_pkg::*;
#(
  parameter int unsigned NTX    = 32,
  parameter int unsigned NRX    = 32,
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [NTX-1:0]    tx_eob_evt,
  input logic [31:0]       rdata,
  input word_t             cfg,
  input word_t             ien,
  input word_t             txeob
);
  logic [31:0] a32;
  assign a32 = 32'(addr);

  // R2: configuration holds its reset value right after reset
  a_r2_cfg_reset: assert property (@(posedge clk)
    $fell(rst) |-> cfg == CFG_RST);

  // R3: soft reset clears the enable, and configuration stores the masked value
  a_r3_soft_reset: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a32 == A_CFG && wdata[31]) |=> (ien == '0 && cfg == ($past(wdata) & M_CFG)));

  // R4: interrupt enable keeps only its low five bits
  a_r4_ien_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a32 == A_IEN) |=> ien == ($past(wdata) & M_IEN));

  // R5: write-1-to-clear with no competing event
  a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a32 == A_TXEOB && tx_eob_evt == '0) |=> (txeob & $past(wdata)) == '0);

  // R6: an event on channel 0 always leaves bit 31 set
  a_r6_evt_set: assert property (@(posedge clk) disable iff (rst)
    tx_eob_evt[0] |=> txeob[31]);

  // R8: an undecoded address reads back as zero
  a_r8_undecoded_zero: assert property (@(posedge clk) disable iff (rst)
    (a32 == 32'h183) |=> rdata == '0);
endmodule

bind dmacr_regfile dmacr_regfile_chk #(.NTX(NTX), .NRX(NRX), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .tx_eob_evt(tx_eob_evt), .rdata(rdata),
  .cfg(cfg_q), .ien(ien_q), .txeob(st_q[1])
);

// File: tb/dmacr_regfile_tb.sv
module dmacr_regfile_tb;
  localparam int NTX = 4;
  localparam int NRX = 2;
  localparam int AW  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [NTX-1:0] tx_eob_evt = '0, tx_derr_evt = '0;
  logic [NRX-1:0] rx_eob_evt = '0, rx_derr_evt = '0;
  logic [31:0] err_evt = '0;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dmacr_regfile #(.NTX(NTX), .NRX(NRX), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tx_eob_evt(tx_eob_evt), .tx_derr_evt(tx_derr_evt),
    .rx_eob_evt(rx_eob_evt), .rx_derr_evt(rx_derr_evt),
    .err_evt(err_evt), .rdata(rdata)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, int a, logic [31:0] exp);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    check(req, rdata, exp);
  endtask

  task automatic t_reset;
    check("R2 rdata", rdata, 32'h0);
    rd_chk("R2 cfg", 'h180, 32'h0007_C000);
    rd_chk("R2 ien", 'h182, 32'h0);
    rd_chk("R2 txptr0", 'h1A0, 32'h0);
  endtask

  task automatic t_masks;
    wr('h182, 32'hFFFF_FFFF); rd_chk("R4 ien", 'h182, 32'h1F);
    wr('h184, 32'hFFFF_FFFF); rd_chk("R4 txset", 'h184, 32'hF000_0000);
    wr('h185, 32'h3FFF_FFFF); rd_chk("R4 txclr", 'h185, 32'h3000_0000);
    wr('h190, 32'hFFFF_FFFF); rd_chk("R4 rxset", 'h190, 32'hC000_0000);
    wr('h191, 32'h7FFF_FFFF); rd_chk("R4 rxclr", 'h191, 32'h4000_0000);
    wr('h1E1, 32'h0000_1234); rd_chk("R4 bsz", 'h1E1, 32'h34);
    wr('h180, 32'h7FFF_FFFF); rd_chk("R4 cfg", 'h180, 32'h00FF_C087);
  endtask

  task automatic t_ranges;
    wr('h1A3, 32'hDEAD_BEEF); rd_chk("R7 txptr3", 'h1A3, 32'hDEAD_BEEF);
    wr('h1A4, 32'h5555_5555); rd_chk("R7 past NTX", 'h1A4, 32'h0);
    rd_chk("R7 txptr0 no alias", 'h1A0, 32'h0);
    wr('h1C1, 32'h0BAD_F00D); rd_chk("R7 rxptr1", 'h1C1, 32'h0BAD_F00D);
    wr('h1C2, 32'h1111_1111); rd_chk("R7 past NRX", 'h1C2, 32'h0);
    rd_chk("R7 rxptr0 no alias", 'h1C0, 32'h0);
    rd_chk("R7 bsz past NRX", 'h1E2, 32'h0);
  endtask

  task automatic t_events;
    @(negedge clk);
    tx_eob_evt = 4'b0101; rx_derr_evt = 2'b10; err_evt = 32'h0000_0101;
    @(negedge clk);
    tx_eob_evt = '0; rx_derr_evt = '0; err_evt = '0;
    @(negedge clk);
    rx_eob_evt = 2'b01;
    @(negedge clk);
    rx_eob_evt = '0;
    rd_chk("R6 txeob", 'h186, 32'hA000_0000);
    rd_chk("R6 rxder", 'h193, 32'h4000_0000);
    rd_chk("R1 rxeob distinct", 'h192, 32'h8000_0000);
    rd_chk("R6 err", 'h181, 32'h0000_0101);
    rd_chk("R1 txder empty", 'h187, 32'h0);
  endtask

  task automatic t_w1c;
    wr('h186, 32'h8000_0000); rd_chk("R5 txeob clr", 'h186, 32'h2000_0000);
    wr('h181, 32'h0000_0001); rd_chk("R5 err clr", 'h181, 32'h0000_0100);
    wr('h181, 32'h0); rd_chk("R5 zero write", 'h181, 32'h0000_0100);
  endtask

  task automatic t_collision;
    @(negedge clk);
    wr_en = 1'b1; addr = AW'('h186); wdata = 32'hF000_0000; tx_eob_evt = 4'b0001;
    @(negedge clk);
    wr_en = 1'b0; tx_eob_evt = '0;
    rd_chk("R6 set beats clear", 'h186, 32'h8000_0000);
  endtask

  task automatic t_soft_reset;
    wr('h182, 32'h1F);
    wr('h184, 32'hF000_0000);
    wr('h180, 32'h8000_0005);
    rd_chk("R3 cfg", 'h180, 32'h0000_0005);
    rd_chk("R3 ien", 'h182, 32'h0);
    rd_chk("R3 txset", 'h184, 32'h0);
    rd_chk("R3 rxclr", 'h191, 32'h0);
    rd_chk("R3 txeob", 'h186, 32'h0);
    rd_chk("R3 err", 'h181, 32'h0);
    rd_chk("R3 rxder", 'h193, 32'h0);
    rd_chk("R10 txptr3 kept", 'h1A3, 32'hDEAD_BEEF);
    rd_chk("R10 bsz1 kept", 'h1E1, 32'h34);
  endtask

  task automatic t_undecoded;
    wr('h182, 32'h3);
    wr('h183, 32'hFFFF_FFFF);
    rd_chk("R8 read 183", 'h183, 32'h0);
    rd_chk("R8 write ignored", 'h182, 32'h3);
    rd_chk("R8 read 188", 'h188, 32'h0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    addr = AW'('h180);
    @(negedge clk);
    addr = AW'('h182);
    check("R9 previous addr", rdata, 32'h5);
    @(negedge clk);
    check("R9 next addr", rdata, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_masks();
    t_ranges();
    t_events();
    t_w1c();
    t_collision();
    t_soft_reset();
    t_undecoded();
    t_latency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule